// File: doc/BRIEF.md
# Grayscale Lamp Matrix Display Controller

This block is a write-only output peripheral that holds a five-by-five picture of lamp brightness values and lights the lamps from it. The CPU addresses it through a shared I/O port: a select strobe carrying a device number picks which peripheral is being talked to, a byte strobe carries one data byte, and a feed strobe closes the line being written. While the display is the selected device, each byte fills the next pixel of the current line. A feed moves writing to the start of the following line, and the fifth feed brings it back to the top line. Selecting the display again always restarts writing at the top-left pixel.

Each pixel stores a 4-bit brightness from 0 (dark) to 15 (brightest). A free-running 4-bit counter is compared against every stored value, so each lamp is on for a fraction of time equal to its level divided by 16. Grid size, level width, device-number width and the display's own device number are parameters.

Top module: `lamp_matrix_ctrl`

## Requirements
- R1: After reset every stored level is 0, so every lamp stays off; the write position is line 0, column 0, and the display is not selected.
- R2: A select strobe whose device number equals 4 makes the display selected and puts the write position at line 0, column 0. A select strobe with any other number deselects it. Byte and feed strobes leave the picture and position unchanged while the display is not selected.
- R3: A byte strobe stores bits 3:0 of the data byte as the level of the pixel at the current line and column, then moves to the next column; bits 7:4 have no effect.
- R4: Once five bytes have been stored in a line, further bytes are dropped until the next feed or select.
- R5: A feed moves the write position to column 0 of the next line and keeps all stored levels.
- R6: A feed on line 4 moves the write position back to line 0, so a sixth line overwrites the top line.
- R7: Lamp output for a pixel of level L is on in exactly L of any 16 consecutive clock cycles; level 0 is never on and level 15 is on in 15 of 16 cycles.
- R8: The pixel at line r, column c drives lamp output bit r*5+c.
- R9: When strobes coincide, select takes precedence over feed and byte, and feed takes precedence over byte; the losing strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_stb | input | 1 | Device select strobe |
| sel_dev | input | 8 | Device number presented with the select strobe |
| wr_stb | input | 1 | Data byte strobe |
| wr_data | input | 8 | Data byte; low nibble is a brightness level |
| feed_stb | input | 1 | End-of-line strobe |
| lamp_on | output | 25 | Lamp enables, bit r*5+c for line r, column c |

## Verification
On every cycle the assertions check that the PWM counter steps by one modulo 16, that the write position stays inside the grid, that a feed lands on column 0 of the next line with wrap from the last line, that a select of the display homes the pointer, that a full line holds its column, and that the picture changes only on an accepted write. The stored picture itself, the nibble masking, the lamp bit mapping and the exact duty cycle per level are only visible through the bench's scenarios, which fill the grid with all sixteen levels and count lamp-on cycles over a full PWM period for every pixel.

// File: rtl/mxd_pkg.sv
package mxd_pkg;
   // Decoded strobe set for one cycle of the I/O port.
   typedef struct packed {
      logic sel;
      logic feed;
      logic wr;
   } port_cmd_t;
endpackage

// File: rtl/mxd_ptr.sv
module mxd_ptr #(
   parameter int ROWS  = 5,
   parameter int COLS  = 5,
   parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
   parameter int COL_W = $clog2(COLS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  mxd_pkg::port_cmd_t cmd,
   input  logic               sel_hit,
   output logic               active,
   output logic               we,
   output logic [ROW_W-1:0]   row,
   output logic [COL_W-1:0]   col
);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0] FULL_COL = COL_W'(COLS);

   logic line_full;
   assign line_full = (col == FULL_COL);
   assign we = !cmd.sel && active && !cmd.feed && cmd.wr && !line_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         row    <= '0;
         col    <= '0;
      end else if (cmd.sel) begin
         active <= sel_hit;
         if (sel_hit) begin
            row <= '0;
            col <= '0;
         end
      end else if (active && cmd.feed) begin
         col <= '0;
         row <= (row == LAST_ROW) ? '0 : row + 1'b1;
      end else if (we) begin
         col <= col + 1'b1;
      end
   end

   // Pointer never leaves the grid (R4, R6)
   p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (col <= FULL_COL) && (row <= LAST_ROW));

   // Feed lands on column 0 of the following line (R5)
   p_feed_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.sel && active && cmd.feed && row != LAST_ROW) |=>
         (col == '0) && (row == $past(row) + 1'b1));

   // Feed on the last line wraps to the top (R6)
   p_feed_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.sel && active && cmd.feed && row == LAST_ROW) |=>
         (col == '0) && (row == '0));

   // Selecting the display homes the pointer (R2)
   p_sel_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.sel && sel_hit) |=> active && (row == '0) && (col == '0));

   // A full line holds its column against further bytes (R4)
   p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.sel && !cmd.feed && line_full) |=> $stable(col) && $stable(row));
endmodule

// File: rtl/mxd_store.sv
module mxd_store #(
   parameter int ROWS    = 5,
   parameter int COLS    = 5,
   parameter int LEVEL_W = 4,
   parameter int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
   parameter int COL_W   = $clog2(COLS + 1),
   parameter int CELLS   = ROWS * COLS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ROW_W-1:0]           row,
   input  logic [COL_W-1:0]           col,
   input  logic [LEVEL_W-1:0]         din,
   output logic [CELLS*LEVEL_W-1:0]   levels
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int IDX = r * COLS + c;
         logic hit;
         assign hit = we && (row == ROW_W'(r)) && (col == COL_W'(c));
         always_ff @(posedge clk) begin
            if (!rst_n)
               levels[IDX*LEVEL_W +: LEVEL_W] <= '0;
            else if (hit)
               levels[IDX*LEVEL_W +: LEVEL_W] <= din;
         end
      end
   end

   // Picture changes only on an accepted byte (R2, R4, R5)
   p_pic_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(levels));
endmodule

// File: rtl/mxd_pwm.sv
module mxd_pwm #(
   parameter int CELLS   = 25,
   parameter int LEVEL_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CELLS*LEVEL_W-1:0]  levels,
   output logic [CELLS-1:0]          lamp_on
);
   logic [LEVEL_W-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= '0;
      else        phase <= phase + 1'b1;
   end

   for (genvar i = 0; i < CELLS; i++) begin : g_cmp
      assign lamp_on[i] = (phase < levels[i*LEVEL_W +: LEVEL_W]);
   end

   // PWM phase steps by one, modulo the level range (R7)
   p_phase_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (phase == LEVEL_W'($past(phase) + 1'b1)));
endmodule

// File: rtl/lamp_matrix_ctrl.sv
module lamp_matrix_ctrl #(
   parameter int ROWS    = 5,
   parameter int COLS    = 5,
   parameter int LEVEL_W = 4,
   parameter int DEV_W   = 8,
   parameter int DEV_ID  = 4,
   parameter int DATA_W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sel_stb,
   input  logic [DEV_W-1:0]       sel_dev,
   input  logic                   wr_stb,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   feed_stb,
   output logic [ROWS*COLS-1:0]   lamp_on
);
   localparam int CELLS = ROWS * COLS;
   localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int COL_W = $clog2(COLS + 1);

   if (ROWS < 1 || COLS < 1 || LEVEL_W < 1 || DATA_W < LEVEL_W)
      $error("lamp_matrix_ctrl: bad geometry or data width");
   if (DEV_ID < 0 || DEV_ID >= (1 << DEV_W))
      $error("lamp_matrix_ctrl: DEV_ID does not fit DEV_W");

   mxd_pkg::port_cmd_t cmd;
   logic               sel_hit;
   logic               active;
   logic               we;
   logic [ROW_W-1:0]   row;
   logic [COL_W-1:0]   col;
   logic [CELLS*LEVEL_W-1:0] levels;

   assign cmd.sel  = sel_stb;
   assign cmd.feed = feed_stb;
   assign cmd.wr   = wr_stb;
   assign sel_hit  = (sel_dev == DEV_W'(DEV_ID));

   mxd_ptr #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel_hit(sel_hit),
      .active(active), .we(we), .row(row), .col(col)
   );

   mxd_store #(.ROWS(ROWS), .COLS(COLS), .LEVEL_W(LEVEL_W),
               .ROW_W(ROW_W), .COL_W(COL_W), .CELLS(CELLS)) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .row(row), .col(col),
      .din(wr_data[LEVEL_W-1:0]), .levels(levels)
   );

   mxd_pwm #(.CELLS(CELLS), .LEVEL_W(LEVEL_W)) u_pwm (
      .clk(clk), .rst_n(rst_n), .levels(levels), .lamp_on(lamp_on)
   );

   // Bytes and feeds leave the grid alone while deselected (R2)
   p_idle_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_stb && !active) |=> $stable(row) && $stable(col) && $stable(levels));
endmodule

// File: tb/lamp_matrix_ctrl_test.sv
`timescale 1ns/1ps
module lamp_matrix_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_stb = 1'b0;
   logic [7:0]  sel_dev = '0;
   logic        wr_stb = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        feed_stb = 1'b0;
   logic [24:0] lamp_on;

   int checks = 0;
   int failures = 0;
   int exp_lvl [25];
   int m_row = 0, m_col = 0;
   bit m_act = 0;

   always #5 clk = ~clk;

   lamp_matrix_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sel_stb(sel_stb), .sel_dev(sel_dev),
      .wr_stb(wr_stb), .wr_data(wr_data), .feed_stb(feed_stb), .lamp_on(lamp_on)
   );

   // One port cycle plus the bench's own model of its effect.
   task automatic port(input bit s, input int dev, input bit f, input bit w, input int d);
      @(negedge clk);
      sel_stb = s; sel_dev = dev[7:0]; feed_stb = f; wr_stb = w; wr_data = d[7:0];
      @(negedge clk);
      sel_stb = 0; feed_stb = 0; wr_stb = 0;
      if (s) begin
         m_act = (dev == 4);
         if (m_act) begin m_row = 0; m_col = 0; end
      end else if (m_act && f) begin
         m_col = 0;
         m_row = (m_row + 1) % 5;
      end else if (m_act && w && m_col < 5) begin
         exp_lvl[m_row*5 + m_col] = d % 16;
         m_col++;
      end
   endtask

   task automatic sel(input int dev);        port(1, dev, 0, 0, 0); endtask
   task automatic wr(input int d);           port(0, 0, 0, 1, d);   endtask
   task automatic feed();                    port(0, 0, 1, 0, 0);   endtask

   // Count on-cycles for every lamp over one full PWM period.
   task automatic measure(input string tag);
      int on_cnt [25];
      for (int i = 0; i < 25; i++) on_cnt[i] = 0;
      repeat (16) begin
         @(negedge clk);
         for (int i = 0; i < 25; i++) on_cnt[i] += int'(lamp_on[i]);
      end
      for (int i = 0; i < 25; i++) begin
         checks++;
         if (on_cnt[i] != exp_lvl[i]) begin
            failures++;
            $display("FAIL %s lamp %0d: on=%0d expected=%0d", tag, i, on_cnt[i], exp_lvl[i]);
         end
      end
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog: run incomplete, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 25; i++) exp_lvl[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: all dark out of reset
      measure("R1 reset");

      // R2: bytes and feeds ignored before any select
      wr(8'h0F); feed(); wr(8'h07);
      measure("R2 unselected");

      // R3 R4 R5 R7 R8: fill the grid with every level, junk in high nibble
      sel(4);
      for (int r = 0; r < 5; r++) begin
         for (int c = 0; c < 5; c++) wr(((r*5 + c) % 16) | ((r + c + 1) << 4));
         wr(8'h9F); wr(8'hEE);   // R4: beyond column 5, dropped
         feed();
      end
      measure("R3/R7/R8 level sweep");

      // R6: after five feeds, next byte lands on line 0 column 0
      wr(8'h3F); wr(8'h01);
      measure("R6 wrap");

      // R5: feed keeps pixels, next line starts at column 0
      feed(); wr(8'h0C);
      measure("R5 feed keep");

      // R2: another device deselects; bytes dropped
      sel(3); wr(8'h05); feed(); wr(8'h06);
      measure("R2 other device");

      // R2: reselect homes the pointer
      sel(4); wr(8'h0A);
      measure("R2 reselect home");

      // R9: select and byte together -> byte dropped, pointer home
      feed(); port(1, 4, 0, 1, 8'h0B); wr(8'h02);
      measure("R9 select beats byte");

      // R9: feed and byte together -> byte dropped, next line
      port(0, 0, 1, 1, 8'h0D); wr(8'h08);
      measure("R9 feed beats byte");

      // R9: select of other device with feed -> deselect wins
      port(1, 2, 1, 1, 8'h0F); wr(8'h0F);
      measure("R9 deselect beats feed");

      // R7: extreme levels 0 and 15 over whole grid
      sel(4);
      for (int r = 0; r < 5; r++) begin
         for (int c = 0; c < 5; c++) wr(((r + c) % 2 == 0) ? 8'h0F : 8'hF0);
         feed();
      end
      measure("R7 extremes");

      // R1: reset clears everything again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 25; i++) exp_lvl[i] = 0;
      m_act = 0; m_row = 0; m_col = 0;
      wr(8'h0F);
      measure("R1 reset clear and deselect");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule